// File: doc/BRIEF.md
# Partitioned Free-Address Allocator

This block keeps the free addresses of a fixed-size cell buffer. The buffer is split into one private region for each output port and one shared region. Each region has its own free-address queue. A cell bound for port k asks for a slot. The allocator serves the request from port k's private queue when that queue has an entry. Otherwise it serves the request from the shared queue, as long as port k has not already used up its quota of shared slots. When neither source can serve the request, the cell is marked for dropping.

When a cell leaves the buffer, its address is returned to the allocator. The allocator sends the address to the tail of the queue that owns it. If the address belongs to the shared region, it also lowers the shared-slot count of the port that released it.

After reset, a fill sequence loads every buffer address into its owning queue, one address per clock. The allocator reports itself not ready until this sequence is complete. The cell data path lives elsewhere.

Top module: `alloc_buffer_pool`

## Requirements
- R1: After reset, `ready` is low and reads low for exactly TOTAL = NUM_PORTS*PRIV_DEPTH + SHARED_DEPTH rising edges. It then stays high until the next reset. A request made while `ready` is low gets neither a grant nor a drop.
- R2: Private region k covers addresses k*PRIV_DEPTH to k*PRIV_DEPTH+PRIV_DEPTH-1. The shared region covers NUM_PORTS*PRIV_DEPTH to TOTAL-1. Every granted address lies in the requesting port's private region or in the shared region.
- R3: A request for port k (a binary index from 0 to NUM_PORTS-1) is served from private queue k whenever that queue is not empty. Addresses come out in queue order, and after the fill sequence that order is ascending.
- R4: When private queue k is empty, the request is served from the shared queue. After the fill sequence, the shared queue hands out addresses in ascending order.
- R5: When the request can be served from neither its private queue nor the shared queue, `alloc_drop` pulses. `alloc_gnt` and `alloc_drop` are never high together.
- R6: A port never holds more than SHARED_LIMIT shared slots at once. A request that would exceed this limit is dropped, even if the shared queue still has free entries.
- R7: A released address is appended to the tail of its own region's queue. Releasing a shared address lowers the shared-slot count of `rel_port`, but never below zero.
- R8: A release whose address is TOTAL or above changes no queue and no count.
- R9: A request sampled at rising edge t produces a grant or a drop at edge t only. The response lasts one cycle.
- R10: An allocation and a release may be presented in the same cycle, and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | output | 1 | High once the fill sequence is complete |
| alloc_req | input | 1 | Allocation request |
| alloc_port | input | PORT_W | Destination port of the cell |
| alloc_gnt | output | 1 | One-cycle pulse: address granted |
| alloc_drop | output | 1 | One-cycle pulse: no slot, drop the cell |
| alloc_addr | output | ADDR_W | Granted address, valid while `alloc_gnt` is high |
| rel_req | input | 1 | Release request |
| rel_port | input | PORT_W | Port that held the released cell |
| rel_addr | input | ADDR_W | Address being returned |

## Verification
The assertions check four properties on every clock cycle:
- grant and drop are mutually exclusive;
- a granted address lies in a legal region for its port;
- no shared-slot count passes its limit;
- `ready` stays high once it rises, and nothing is answered before it does.

The queues also check that they are never popped while empty and never pushed while full.

Some behaviours can only be shown by the bench's scenarios. These are the ordering between private and shared sources, the exact address sequence, the tail placement of released addresses, and the point at which the quota or an empty shared queue turns a request into a drop.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_PRIV   = 2'd1,
        SRC_SHARED = 2'd2
    } alloc_src_e;
endpackage

// File: rtl/alloc_free_fifo.sv
module alloc_free_fifo #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              pop_i,
    output logic [ADDR_W-1:0] head_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] mem;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        logic do_push, do_pop;
        s_d     = s_q;
        do_push = push_i && (int'(s_q.cnt) < DEPTH);
        do_pop  = pop_i && (s_q.cnt != '0);
        if (do_push) begin
            s_d.mem[s_q.wr] = push_addr_i;
            s_d.wr          = bump(s_q.wr);
        end
        if (do_pop) begin
            s_d.rd = bump(s_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head_o  = s_q.mem[s_q.rd];
    assign empty_o = (s_q.cnt == '0);
    assign full_o  = (int'(s_q.cnt) == DEPTH);

    // R5: the owner never takes from an empty queue
    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (s_q.cnt != '0));
    // R7: a release never lands on a queue that is already full
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (int'(s_q.cnt) < DEPTH));
endmodule

// File: rtl/alloc_region_dec.sv
module alloc_region_dec #(
    parameter int NUM_PORTS    = 4,
    parameter int PRIV_DEPTH   = 4,
    parameter int SHARED_DEPTH = 8,
    parameter int ADDR_W       = 5,
    parameter int PORT_W       = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              valid_o,
    output logic              shared_o,
    output logic [PORT_W-1:0] port_o
);
    localparam int SHARED_BASE = NUM_PORTS * PRIV_DEPTH;
    localparam int TOTAL       = SHARED_BASE + SHARED_DEPTH;

    always_comb begin
        valid_o  = 1'b0;
        shared_o = 1'b0;
        port_o   = '0;
        if (int'(addr_i) < SHARED_BASE) begin
            valid_o = 1'b1;
            port_o  = PORT_W'(int'(addr_i) / PRIV_DEPTH);
        end else if (int'(addr_i) < TOTAL) begin
            valid_o  = 1'b1;
            shared_o = 1'b1;
        end
    end
endmodule

// File: rtl/alloc_buffer_pool.sv
module alloc_buffer_pool #(
    parameter int NUM_PORTS    = 4,
    parameter int PRIV_DEPTH   = 4,
    parameter int SHARED_DEPTH = 8,
    parameter int SHARED_LIMIT = 3,
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int TOTAL  = NUM_PORTS * PRIV_DEPTH + SHARED_DEPTH,
    localparam int ADDR_W = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ready,
    input  logic              alloc_req,
    input  logic [PORT_W-1:0] alloc_port,
    output logic              alloc_gnt,
    output logic              alloc_drop,
    output logic [ADDR_W-1:0] alloc_addr,
    input  logic              rel_req,
    input  logic [PORT_W-1:0] rel_port,
    input  logic [ADDR_W-1:0] rel_addr
);
    import alloc_pkg::*;

    localparam int SHARED_BASE = NUM_PORTS * PRIV_DEPTH;
    localparam int SCNT_W      = $clog2(SHARED_LIMIT + 1);
    localparam int IDX_W       = $clog2(TOTAL + 1);

    typedef struct packed {
        logic                             ready;
        logic [IDX_W-1:0]                 init_idx;
        logic                             gnt;
        logic                             drop;
        logic [ADDR_W-1:0]                addr;
        logic [PORT_W-1:0]                gnt_port;
        logic [NUM_PORTS-1:0][SCNT_W-1:0] shr_cnt;
    } pool_state_t;

    pool_state_t s_d, s_q;

    logic [NUM_PORTS-1:0]             priv_push, priv_pop, priv_empty, priv_full;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] priv_head;
    logic                             shr_push, shr_pop, shr_empty, shr_full;
    logic [ADDR_W-1:0]                shr_head;
    logic [ADDR_W-1:0]                push_addr;
    logic                             dec_valid, dec_shared;
    logic [PORT_W-1:0]                dec_port;
    alloc_src_e                       src;

    // The decoder serves the fill sequence first, then releases
    assign push_addr = s_q.ready ? rel_addr : ADDR_W'(s_q.init_idx);

    alloc_region_dec #(
        .NUM_PORTS(NUM_PORTS), .PRIV_DEPTH(PRIV_DEPTH),
        .SHARED_DEPTH(SHARED_DEPTH), .ADDR_W(ADDR_W), .PORT_W(PORT_W)
    ) u_dec (
        .addr_i(push_addr), .valid_o(dec_valid),
        .shared_o(dec_shared), .port_o(dec_port)
    );

    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_priv
        alloc_free_fifo #(.DEPTH(PRIV_DEPTH), .ADDR_W(ADDR_W)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push_i(priv_push[k]), .push_addr_i(push_addr),
            .pop_i(priv_pop[k]), .head_o(priv_head[k]),
            .empty_o(priv_empty[k]), .full_o(priv_full[k])
        );
    end

    alloc_free_fifo #(.DEPTH(SHARED_DEPTH), .ADDR_W(ADDR_W)) u_shared (
        .clk(clk), .rst_n(rst_n),
        .push_i(shr_push), .push_addr_i(push_addr),
        .pop_i(shr_pop), .head_o(shr_head),
        .empty_o(shr_empty), .full_o(shr_full)
    );

    always_comb begin
        logic              take, port_ok, priv_avail, shr_room, do_push;
        logic [ADDR_W-1:0] priv_sel;
        s_d        = s_q;
        s_d.gnt    = 1'b0;
        s_d.drop   = 1'b0;
        priv_push  = '0;
        priv_pop   = '0;
        shr_push   = 1'b0;
        shr_pop    = 1'b0;
        src        = SRC_NONE;
        port_ok    = 1'b0;
        priv_avail = 1'b0;
        priv_sel   = '0;
        shr_room   = 1'b0;
        for (int k = 0; k < NUM_PORTS; k++) begin
            if (int'(alloc_port) == k) begin
                port_ok    = 1'b1;
                priv_avail = !priv_empty[k];
                priv_sel   = priv_head[k];
                shr_room   = int'(s_q.shr_cnt[k]) < SHARED_LIMIT;
            end
        end

        // allocation: private first, shared under quota, else drop
        take = s_q.ready && alloc_req;
        if (take) begin
            if (port_ok && priv_avail)                 src = SRC_PRIV;
            else if (port_ok && !shr_empty && shr_room) src = SRC_SHARED;
            s_d.gnt_port = alloc_port;
            case (src)
                SRC_PRIV: begin
                    priv_pop[alloc_port] = 1'b1;
                    s_d.gnt  = 1'b1;
                    s_d.addr = priv_sel;
                end
                SRC_SHARED: begin
                    shr_pop  = 1'b1;
                    s_d.gnt  = 1'b1;
                    s_d.addr = shr_head;
                    s_d.shr_cnt[alloc_port] = s_q.shr_cnt[alloc_port] + 1'b1;
                end
                default: s_d.drop = 1'b1;
            endcase
        end

        // fill sequence before ready, releases after
        do_push = s_q.ready ? (rel_req && dec_valid) : 1'b1;
        if (!s_q.ready) begin
            s_d.init_idx = s_q.init_idx + 1'b1;
            s_d.ready    = (int'(s_q.init_idx) == TOTAL - 1);
        end
        if (do_push) begin
            if (dec_shared) begin
                shr_push = 1'b1;
                if (s_q.ready) begin
                    for (int k = 0; k < NUM_PORTS; k++) begin
                        if (int'(rel_port) == k && s_d.shr_cnt[k] != '0)
                            s_d.shr_cnt[k] = s_d.shr_cnt[k] - 1'b1;
                    end
                end
            end else begin
                priv_push[dec_port] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready      = s_q.ready;
    assign alloc_gnt  = s_q.gnt;
    assign alloc_drop = s_q.drop;
    assign alloc_addr = s_q.addr;

    p_quiet_before_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !(alloc_gnt || alloc_drop));
    p_ready_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    p_addr_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |-> ((int'(alloc_addr) >= SHARED_BASE && int'(alloc_addr) < TOTAL) ||
                       (int'(alloc_addr) / PRIV_DEPTH == int'(s_q.gnt_port))));
    p_gnt_drop_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_gnt && alloc_drop));
    p_resp_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_gnt || alloc_drop) |-> $past(alloc_req));
    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_lim
        p_shr_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
            int'(s_q.shr_cnt[k]) <= SHARED_LIMIT);
    end
endmodule

// File: tb/alloc_buffer_pool_test.sv
module alloc_buffer_pool_test;
    localparam int CLK_PERIOD = 10;
    localparam int TOTAL      = 24;
    localparam int NV         = 33;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ready, alloc_gnt, alloc_drop;
    logic       alloc_req = 1'b0, rel_req = 1'b0;
    logic [1:0] alloc_port = '0, rel_port = '0;
    logic [4:0] alloc_addr, rel_addr = '0;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    alloc_buffer_pool uut (
        .clk(clk), .rst_n(rst_n), .ready(ready),
        .alloc_req(alloc_req), .alloc_port(alloc_port),
        .alloc_gnt(alloc_gnt), .alloc_drop(alloc_drop), .alloc_addr(alloc_addr),
        .rel_req(rel_req), .rel_port(rel_port), .rel_addr(rel_addr)
    );

    typedef struct packed {
        logic       req;
        logic [1:0] port;
        logic       rel;
        logic [1:0] rport;
        logic [4:0] raddr;
        logic       eg;
        logic       ed;
        logic [4:0] ea;
        logic [3:0] tag;
    } vec_t;

    // port0 0..3, port1 4..7, port2 8..11, port3 12..15, shared 16..23, quota 3
    localparam vec_t VECS [NV] = '{
        '{1, 0, 0, 0, 0,  1, 0, 0,  3},  // R3 ascending private
        '{1, 0, 0, 0, 0,  1, 0, 1,  3},
        '{1, 1, 0, 0, 0,  1, 0, 4,  3},
        '{1, 0, 0, 0, 0,  1, 0, 2,  3},
        '{1, 0, 0, 0, 0,  1, 0, 3,  3},
        '{1, 0, 0, 0, 0,  1, 0, 16, 4},  // R4 fallback to shared
        '{1, 0, 0, 0, 0,  1, 0, 17, 4},
        '{1, 0, 0, 0, 0,  1, 0, 18, 4},
        '{1, 0, 0, 0, 0,  0, 1, 0,  6},  // R6 quota reached
        '{0, 0, 1, 0, 1,  0, 0, 0,  7},  // R7 release private 1
        '{1, 0, 0, 0, 0,  1, 0, 1,  7},
        '{0, 0, 1, 0, 17, 0, 0, 0,  7},  // R7 release shared 17
        '{1, 0, 0, 0, 0,  1, 0, 19, 7},
        '{0, 0, 1, 0, 30, 0, 0, 0,  8},  // R8 invalid release
        '{1, 0, 0, 0, 0,  0, 1, 0,  8},
        '{1, 3, 0, 0, 0,  1, 0, 12, 2},  // R2 port 3 region
        '{1, 1, 1, 1, 4,  1, 0, 5, 10},  // R10 alloc and release together
        '{1, 1, 0, 0, 0,  1, 0, 6,  3},
        '{1, 1, 0, 0, 0,  1, 0, 7,  3},
        '{1, 1, 0, 0, 0,  1, 0, 4,  7},  // R7 released at tail
        '{1, 1, 0, 0, 0,  1, 0, 20, 4},
        '{1, 1, 0, 0, 0,  1, 0, 21, 4},
        '{1, 1, 0, 0, 0,  1, 0, 22, 4},
        '{1, 1, 0, 0, 0,  0, 1, 0,  6},
        '{1, 2, 0, 0, 0,  1, 0, 8,  3},
        '{1, 2, 0, 0, 0,  1, 0, 9,  3},
        '{1, 2, 0, 0, 0,  1, 0, 10, 3},
        '{1, 2, 0, 0, 0,  1, 0, 11, 3},
        '{1, 2, 0, 0, 0,  1, 0, 23, 4},
        '{1, 2, 0, 0, 0,  1, 0, 17, 7},
        '{1, 2, 0, 0, 0,  0, 1, 0,  5},  // R5 both empty
        '{0, 0, 1, 2, 23, 0, 0, 0,  7},
        '{1, 2, 0, 0, 0,  1, 0, 23, 7}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic alloc_once(input logic [1:0] p, input int exp_addr, input string req);
        @(negedge clk);
        alloc_req = 1'b1; alloc_port = p;
        @(posedge clk);
        @(negedge clk);
        alloc_req = 1'b0;
        check(alloc_gnt && alloc_addr == 5'(exp_addr), req, int'(alloc_addr), exp_addr);
    endtask

    task automatic run_reset(input string req);
        int n;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!ready && !alloc_gnt && !alloc_drop, req, int'(ready), 0);
        rst_n = 1'b1;
        alloc_req = 1'b1; alloc_port = 2'd0;   // R1 ignored during fill
        n = 0;
        while (!ready && n < 100) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (alloc_gnt || alloc_drop)
                check(1'b0, "R1 response during fill", 1, 0);
        end
        alloc_req = 1'b0;
        check(n == TOTAL, "R1 fill length", n, TOTAL);
    endtask

    initial begin
        run_reset("R1 reset state");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            alloc_req  = VECS[i].req;  alloc_port = VECS[i].port;
            rel_req    = VECS[i].rel;  rel_port   = VECS[i].rport;
            rel_addr   = VECS[i].raddr;
            @(posedge clk);
            @(negedge clk);
            alloc_req = 1'b0; rel_req = 1'b0;
            check(alloc_gnt == VECS[i].eg, $sformatf("R%0d vector %0d gnt", VECS[i].tag, i),
                  int'(alloc_gnt), int'(VECS[i].eg));
            check(alloc_drop == VECS[i].ed, $sformatf("R%0d vector %0d drop", VECS[i].tag, i),
                  int'(alloc_drop), int'(VECS[i].ed));
            if (VECS[i].eg)
                check(alloc_addr == VECS[i].ea, $sformatf("R%0d vector %0d addr", VECS[i].tag, i),
                      int'(alloc_addr), int'(VECS[i].ea));
        end

        // R9: single-cycle response
        alloc_once(2'd3, 13, "R9 grant");
        @(posedge clk);
        @(negedge clk);
        check(!alloc_gnt && !alloc_drop, "R9 pulse width", int'(alloc_gnt), 0);

        // R1: a second reset refills every queue from scratch
        run_reset("R1 mid-run reset");
        alloc_once(2'd0, 0, "R3 after refill");
        alloc_once(2'd3, 12, "R2 after refill");
        check(ready, "R1 ready held", int'(ready), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule